// File: doc/BRIEF.md
# ADC Group Result Buffer

This block stores conversion results for a single ADC group in a circular memory of fixed depth. A conversion sequencer presents each result with a valid strobe. The CPU pulls results out one at a time with a read strobe, and the popped word appears on the read data port in the following cycle. The current occupancy is always visible as a fill level.

The sequencer can deliver a result while the memory is full. A policy bit selects what happens then:

- **Wrap policy:** the stored contents are thrown away and the new result becomes the only entry.
- **Stall policy:** the result is lost and a sticky overrun flag is raised. Later results are refused until the CPU has emptied the memory.

A separate down-counter is preset by software while the group is idle. It steps down once for every result that is actually stored. When it moves from 1 to 0 it raises a threshold flag, which becomes an interrupt request if enabled. This lets the CPU service a batch of results with a single interrupt.

Top module: `adc_group_buffer`

## Requirements
- R1: While reset is asserted, fill_level, rd_data, ovr_flag, thr_flag and irq are all zero.
- R2: Stored results leave in arrival order. After a pop of a non-empty buffer, rd_data holds the oldest entry from the next cycle on, and holds it until the next pop.
- R3: fill_level stays within 0 to DEPTH (default 16). A cycle that both stores and pops leaves fill_level unchanged, and this includes the full case, where the result is accepted without any overrun.
- R4: A pop while fill_level is 0 loads zero into rd_data and leaves the read position unchanged. A result presented in that same cycle is still stored.
- R5: With wrap_en = 1, a result arriving at full level without a pop in the same cycle discards all stored entries. The next cycle shows fill_level 1, that result is the next one popped, and ovr_flag is not set.
- R6: With wrap_en = 0, a result arriving at full level without a pop is dropped and ovr_flag is set. ovr_flag stays set until a cycle with ovr_clr = 1 and no new drop. In a cycle that both drops and clears, the flag stays set.
- R7: With wrap_en = 0, once a result has been dropped, every later result is also dropped (and sets ovr_flag) until pops bring fill_level to 0. Results are accepted again from the cycle after fill_level reads 0.
- R8: thr_load copies thr_value into the threshold counter only when grp_active = 0. A thr_load while grp_active = 1 has no effect.
- R9: The threshold counter decrements once per stored result; dropped results do not count. thr_flag is set on the step from 1 to 0. At 0 the counter holds, and further results raise no flag until it is reloaded.
- R10: irq equals thr_flag AND irq_en in the same cycle. thr_clr clears thr_flag, but a flag set in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_valid | input | 1 | A conversion result is presented this cycle |
| res_data | input | DATA_W | Conversion result |
| rd_pop | input | 1 | CPU read strobe: remove the oldest entry |
| rd_data | output | DATA_W | Word returned by the last pop (zero if the buffer was empty) |
| thr_load | input | 1 | Load strobe for the threshold counter |
| thr_value | input | THR_W | Threshold preset value |
| grp_active | input | 1 | Group is converting; blocks threshold loads |
| wrap_en | input | 1 | 1: wrap and discard when full, 0: stall on overrun |
| irq_en | input | 1 | Threshold interrupt enable |
| ovr_clr | input | 1 | Write-1-to-clear strobe for ovr_flag |
| thr_clr | input | 1 | Clear strobe for thr_flag |
| fill_level | output | CNT_W | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun indication |
| thr_flag | output | 1 | Threshold reached |
| irq | output | 1 | Threshold interrupt request |

## Verification
The key collision is a sequencer store that lands in the same cycle as a CPU pop when the buffer is full. This must count as a free slot and not as an overrun.

The bench fills the memory to its full depth in stall mode and then drives a result together with a pop. It expects three things: fill_level stays at full, the oldest word appears on rd_data, and ovr_flag stays clear.

A second collision pairs an overrun drop with ovr_clr in the same cycle. The flag is expected to survive that cycle and fall only on a following clear with no drop.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

  // Action taken on the incoming result in a given cycle
  typedef enum logic [1:0] {
    WR_IDLE    = 2'd0,  // nothing presented
    WR_STORE   = 2'd1,  // result appended
    WR_RESTART = 2'd2,  // memory discarded, result becomes sole entry
    WR_DROP    = 2'd3   // result lost (overrun or stall)
  } wr_act_e;

  function automatic logic is_stored(input wr_act_e a);
    return (a == WR_STORE) || (a == WR_RESTART);
  endfunction

endpackage

// File: rtl/adc_buf_rst_sync.sv
module adc_buf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adc_buf_mem.sv
module adc_buf_mem #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] entry_q [DEPTH];

  // One clock-enabled register bank per slot; storage needs no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) entry_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_word = entry_q[rd_ptr];
  end

endmodule

// File: rtl/adc_buf_ctrl.sv
module adc_buf_ctrl
  import adc_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic             rd_pop,
  input  logic             wrap_en,
  input  logic             ovr_clr,
  output wr_act_e          wr_act,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             pop_ok,
  output logic [CNT_W-1:0] fill_level,
  output logic             ovr_flag
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stall_q, stall_d;
  logic             ovr_q, ovr_d;
  logic             full_eff;
  wr_act_e          act;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // Decide what happens to the incoming result
  always_comb begin
    pop_ok   = rd_pop && (cnt_q != '0);
    full_eff = (cnt_q == FULL_LVL) && !pop_ok;
    if (!res_valid)    act = WR_IDLE;
    else if (stall_q)  act = WR_DROP;
    else if (full_eff) act = wrap_en ? WR_RESTART : WR_DROP;
    else               act = WR_STORE;
  end

  // Next-state for pointers, level, stall and overrun
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    unique case (act)
      WR_STORE: begin
        wr_ptr_d = ptr_inc(wr_ptr_q);
        if (pop_ok) rd_ptr_d = ptr_inc(rd_ptr_q);
        else        cnt_d    = cnt_q + 1'b1;
      end
      WR_RESTART: begin
        rd_ptr_d = wr_ptr_q;
        wr_ptr_d = ptr_inc(wr_ptr_q);
        cnt_d    = CNT_W'(1);
      end
      default: begin
        if (pop_ok) begin
          rd_ptr_d = ptr_inc(rd_ptr_q);
          cnt_d    = cnt_q - 1'b1;
        end
      end
    endcase
    stall_d = (stall_q || (act == WR_DROP)) && (cnt_d != '0);
    if (act == WR_DROP) ovr_d = 1'b1;
    else if (ovr_clr)   ovr_d = 1'b0;
    else                ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      stall_q  <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      stall_q  <= stall_d;
      ovr_q    <= ovr_d;
    end
  end

  assign wr_act     = act;
  assign wr_ptr     = wr_ptr_q;
  assign rd_ptr     = rd_ptr_q;
  assign fill_level = cnt_q;
  assign ovr_flag   = ovr_q;

endmodule

// File: rtl/adc_buf_thresh.sv
module adc_buf_thresh #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_load,
  input  logic [THR_W-1:0] thr_value,
  input  logic             grp_active,
  input  logic             stored,
  input  logic             thr_clr,
  input  logic             irq_en,
  output logic             thr_flag,
  output logic             irq
);

  localparam logic [THR_W-1:0] ONE = THR_W'(1);

  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             load_ok;
  logic             hit;

  always_comb begin
    load_ok = thr_load && !grp_active;
    hit     = !load_ok && stored && (cnt_q == ONE);
    cnt_d   = cnt_q;
    if (load_ok)                     cnt_d = thr_value;
    else if (stored && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    if (hit)          flag_d = 1'b1;
    else if (thr_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign thr_flag = flag_q;
  assign irq      = flag_q && irq_en;

endmodule

// File: rtl/adc_group_buffer.sv
module adc_group_buffer
  import adc_buf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  input  logic              thr_load,
  input  logic [THR_W-1:0]  thr_value,
  input  logic              grp_active,
  input  logic              wrap_en,
  input  logic              irq_en,
  input  logic              ovr_clr,
  input  logic              thr_clr,
  output logic [CNT_W-1:0]  fill_level,
  output logic              ovr_flag,
  output logic              thr_flag,
  output logic              irq
);

  logic              rst_int_n;
  wr_act_e           wr_act;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              pop_ok;
  logic              stored;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;

  adc_buf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  adc_buf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .res_valid  (res_valid),
    .rd_pop     (rd_pop),
    .wrap_en    (wrap_en),
    .ovr_clr    (ovr_clr),
    .wr_act     (wr_act),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .pop_ok     (pop_ok),
    .fill_level (fill_level),
    .ovr_flag   (ovr_flag)
  );

  assign stored = is_stored(wr_act);

  adc_buf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk     (clk),
    .wr_en   (stored),
    .wr_ptr  (wr_ptr),
    .wr_data (res_data),
    .rd_ptr  (rd_ptr),
    .rd_word (rd_word)
  );

  adc_buf_thresh #(.THR_W(THR_W)) u_thr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .thr_load   (thr_load),
    .thr_value  (thr_value),
    .grp_active (grp_active),
    .stored     (stored),
    .thr_clr    (thr_clr),
    .irq_en     (irq_en),
    .thr_flag   (thr_flag),
    .irq        (irq)
  );

  // Read data register: updated on every pop, zero for an empty pop
  always_comb begin
    rd_data_d = pop_ok ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_data_q <= '0;
    else if (rd_pop) rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/adc_buf_chk.sv
module adc_buf_chk #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              rd_pop,
  input logic              wrap_en,
  input logic              ovr_clr,
  input logic              thr_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  fill_level,
  input logic              ovr_flag,
  input logic              thr_flag
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= FULL_LVL);

  // R4
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fill_level == '0) |=> (rd_data == '0));

  // R5
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && fill_level == FULL_LVL && res_valid && !rd_pop)
      |=> (fill_level == CNT_W'(1)));

  // R6
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en && fill_level == FULL_LVL && res_valid && !rd_pop)
      |=> (ovr_flag && fill_level == FULL_LVL));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R9
  thr_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_flag) |-> $past(res_valid));

  // R10
  thr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_flag && !thr_clr) |=> thr_flag);

endmodule

bind adc_group_buffer adc_buf_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .rd_pop     (rd_pop),
  .wrap_en    (wrap_en),
  .ovr_clr    (ovr_clr),
  .thr_clr    (thr_clr),
  .rd_data    (rd_data),
  .fill_level (fill_level),
  .ovr_flag   (ovr_flag),
  .thr_flag   (thr_flag)
);

// File: tb/sim_adc_group_buffer.sv
module sim_adc_group_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 16;
  localparam int THR_W  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NVEC   = 8;

  // vector: [31] valid, [30] pop, [29:18] data, [17:13] exp level,
  //         [12] check rd_data, [11:0] exp rd_data
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 12'h111, 5'd1, 1'b0, 12'h000},
    {1'b1, 1'b0, 12'h222, 5'd2, 1'b0, 12'h000},
    {1'b0, 1'b1, 12'h000, 5'd1, 1'b1, 12'h111},
    {1'b1, 1'b1, 12'h333, 5'd1, 1'b1, 12'h222},
    {1'b0, 1'b1, 12'h000, 5'd0, 1'b1, 12'h333},
    {1'b0, 1'b1, 12'h000, 5'd0, 1'b1, 12'h000},
    {1'b1, 1'b1, 12'h444, 5'd1, 1'b1, 12'h000},
    {1'b0, 1'b1, 12'h000, 5'd0, 1'b1, 12'h444}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              res_valid = 1'b0;
  logic [DATA_W-1:0] res_data = '0;
  logic              rd_pop = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              thr_load = 1'b0;
  logic [THR_W-1:0]  thr_value = '0;
  logic              grp_active = 1'b0;
  logic              wrap_en = 1'b0;
  logic              irq_en = 1'b0;
  logic              ovr_clr = 1'b0;
  logic              thr_clr = 1'b0;
  logic [CNT_W-1:0]  fill_level;
  logic              ovr_flag;
  logic              thr_flag;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_group_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .thr_load(thr_load),
    .thr_value(thr_value), .grp_active(grp_active), .wrap_en(wrap_en),
    .irq_en(irq_en), .ovr_clr(ovr_clr), .thr_clr(thr_clr),
    .fill_level(fill_level), .ovr_flag(ovr_flag), .thr_flag(thr_flag),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of strobes, return at the following falling edge
  task automatic step(input logic v, input logic [DATA_W-1:0] d, input logic p);
    res_valid = v;
    res_data  = d;
    rd_pop    = p;
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    rd_pop    = 1'b0;
    thr_load  = 1'b0;
    ovr_clr   = 1'b0;
    thr_clr   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: outputs idle while reset held
    chk("R1 level", 32'(fill_level), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 flags", {29'd0, ovr_flag, thr_flag, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4: table of push/pop patterns, stall mode
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][31], VEC[i][29:18], VEC[i][30]);
      chk($sformatf("R3 level vec%0d", i), 32'(fill_level), 32'(VEC[i][17:13]));
      if (VEC[i][12])
        chk($sformatf("R2/R4 rd_data vec%0d", i), 32'(rd_data), 32'(VEC[i][11:0]));
    end

    // R8: preload threshold 18 while idle
    thr_value = 8'd18; thr_load = 1'b1;
    step(1'b0, '0, 1'b0);
    grp_active = 1'b1;
    irq_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1'b1, DATA_W'(12'h500 + i), 1'b0);
    chk("R3 full level", 32'(fill_level), DEPTH);
    chk("R6 no overrun yet", 32'(ovr_flag), 0);
    // R3: store and pop together at full
    step(1'b1, 12'h5FF, 1'b1);
    chk("R3 full store+pop level", 32'(fill_level), DEPTH);
    chk("R2 full store+pop data", 32'(rd_data), 12'h500);
    chk("R3 full store+pop no ovr", 32'(ovr_flag), 0);
    // R6: drop together with clear, set wins
    ovr_clr = 1'b1;
    step(1'b1, 12'hAAA, 1'b0);
    chk("R6 drop sets ovr", 32'(ovr_flag), 1);
    chk("R6 drop keeps level", 32'(fill_level), DEPTH);
    chk("R9 dropped not counted", 32'(thr_flag), 0);
    ovr_clr = 1'b1;
    step(1'b0, '0, 1'b0);
    chk("R6 clear", 32'(ovr_flag), 0);
    step(1'b0, '0, 1'b1);
    chk("R2 pop after drop", 32'(rd_data), 12'h501);
    // R7: still stalled below full
    step(1'b1, 12'hBBB, 1'b0);
    chk("R7 stalled drop level", 32'(fill_level), 15);
    chk("R7 stalled drop ovr", 32'(ovr_flag), 1);
    for (int i = 2; i < DEPTH; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R2 drain order", 32'(rd_data), 32'(12'h500 + i));
    end
    step(1'b0, '0, 1'b1);
    chk("R2 drain last", 32'(rd_data), 12'h5FF);
    chk("R7 empty", 32'(fill_level), 0);
    step(1'b1, 12'hCCC, 1'b0);
    chk("R7 accepted after empty", 32'(fill_level), 1);
    chk("R9 flag on 1->0", 32'(thr_flag), 1);
    chk("R10 irq enabled", 32'(irq), 1);
    step(1'b0, '0, 1'b1);
    chk("R7 resumed data", 32'(rd_data), 12'hCCC);
    thr_clr = 1'b1;
    ovr_clr = 1'b1;
    step(1'b0, '0, 1'b0);
    chk("R10 clear flag", 32'(thr_flag), 0);
    chk("R10 clear irq", 32'(irq), 0);
    step(1'b1, 12'hD01, 1'b0);
    chk("R9 holds at zero", 32'(thr_flag), 0);
    // R8: load while active ignored
    thr_value = 8'd1; thr_load = 1'b1;
    step(1'b0, '0, 1'b0);
    step(1'b1, 12'hD02, 1'b0);
    chk("R8 active load ignored", 32'(thr_flag), 0);
    grp_active = 1'b0;
    irq_en = 1'b0;
    thr_value = 8'd2; thr_load = 1'b1;
    step(1'b0, '0, 1'b0);
    step(1'b1, 12'hD03, 1'b0);
    chk("R8 loaded 2 first", 32'(thr_flag), 0);
    step(1'b1, 12'hD04, 1'b0);
    chk("R8 loaded 2 second", 32'(thr_flag), 1);
    chk("R10 irq masked", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    chk("R10 irq follows enable", 32'(irq), 1);
    thr_clr = 1'b1;
    step(1'b0, '0, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R2 order D0x", 32'(rd_data), 32'(12'hD00 + i));
    end

    // R5: wrap policy
    wrap_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1'b1, DATA_W'(12'h600 + i), 1'b0);
    step(1'b1, 12'h777, 1'b0);
    chk("R5 restart level", 32'(fill_level), 1);
    chk("R5 no ovr", 32'(ovr_flag), 0);
    step(1'b0, '0, 1'b1);
    chk("R5 new result first", 32'(rd_data), 12'h777);
    chk("R5 empty after", 32'(fill_level), 0);

    // R1: asynchronous reset mid-run
    step(1'b1, 12'h888, 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b1, 12'h999, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 async level", 32'(fill_level), 0);
    chk("R1 async rd_data", 32'(rd_data), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule